// File: doc/BRIEF.md
# Phase-Delayed Toggle Waveform Generator

The block drives a bank of square-wave outputs from one shared up-counting base timer. Each channel holds a compare value and flips its output state on the clock in which the base timer equals that value. All channels therefore run at the same frequency. The compare value sets each channel's phase offset.

The base timer either wraps freely over its full 16-bit range or restarts at a programmable value. In free-running mode each output period is 2×65536 clocks. When the timer restarts at value n, each output period is 2(n+2) clocks. The restart value comes from one of two places: channel 0's compare register, which takes channel 0 away from waveform duty, or a separate period register.

Each channel has an idle level and an output-invert bit. Each channel also has a sticky match flag that software clears through a simple synchronous write port.

Top module: `pdw_gen`

## Requirements
- R1: After reset every register is zero, the timer is stopped, and all outputs and flags read 0.
- R2: While the run bit is 0, the timer is held at 0, no match occurs, and output j equals idle-level bit j XOR invert bit j. This value appears two clocks after the write that sets the levels.
- R3: With the run bit set and free-running selected, the timer steps by one each clock and wraps from 0xFFFF to 0. Each channel's output toggles once per 65536 clocks.
- R4: Restart-select value 3'b001 restarts the timer at n = channel 0's compare value. The timer shows 0…n, holds n for one more clock, then returns to 0. Channels 1 to 7 toggle every n+2 clocks. Output 0 stays at its idle level XOR invert.
- R5: Restart-select value 3'b010 restarts the timer at n = the period register. All channels toggle every n+2 clocks.
- R6: A compare match sets that channel's flag on the same edge that updates the output. The flag stays set until software clears it.
- R7: A write to the flag-clear address clears flag j where data bit j is 0, and leaves flag j unchanged where data bit j is 1. A match on the same clock wins over the clear.
- R8: No match is evaluated during the extra hold clock. A channel whose compare value equals n toggles exactly once per n+2 clocks.
- R9: If the run bit is written at edge E, the timer reads 0 after E. A channel with compare value m toggles its output at edge E+m+1.
- R10: Register map, 4-bit address. Writes take effect at the sampling edge.
  - Address 0: bit 0 is the run bit; bits 3:1 are the restart select. Any select value other than 001 or 010 means free-running.
  - Address 1: period register.
  - Address 2: bits 7:0 are the idle levels; bits 15:8 are the invert bits.
  - Address 3: flag clear.
  - Addresses 8+j: compare value of channel j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base-timer clock |
| rst | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| wave_o | output | 8 | Registered waveform outputs |
| flag_o | output | 8 | Sticky match flags (readback) |

## Verification
Directed patterns measure the gap between output edges in each timer mode:
- free-running gives 65536;
- channel-0 restart at 10 gives 12;
- period-register restart at 20 gives 22.

These gaps separate a correct hold cycle from a missing or doubled one. A channel whose compare value equals the restart value separates "no match in the hold clock" from a double toggle. A clear written in exactly the match cycle separates match priority from clear priority. An unlisted select code tells apart a decoder that falls back to free-running from one that freezes channel 0. Seeded random register writes, mixing modes, phases, levels, inversion and clears, are compared cycle by cycle against a bench model.

// File: rtl/pdw_pkg.sv
`timescale 1ns/1ps
package pdw_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CMP0 = 2'd1,
    MODE_PREG = 2'd2
  } tmode_e;

  localparam int A_CTRL = 0;
  localparam int A_PER  = 1;
  localparam int A_LVL  = 2;
  localparam int A_FCLR = 3;
  localparam int A_CMP  = 8;
  localparam int INV_LSB = 8;

  function automatic tmode_e pick_mode(input logic [2:0] sel);
    case (sel)
      3'b001:  return MODE_CMP0;
      3'b010:  return MODE_PREG;
      default: return MODE_FREE;
    endcase
  endfunction

endpackage

// File: rtl/pdw_regs.sv
`timescale 1ns/1ps
module pdw_regs
  import pdw_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [TW-1:0]           wdata,
  output logic                    en,
  output logic [2:0]              rsel,
  output logic [TW-1:0]           per,
  output logic [NCH-1:0]          lvl,
  output logic [NCH-1:0]          inv,
  output logic [NCH-1:0][TW-1:0]  cmp,
  output logic                    clr,
  output logic [NCH-1:0]          keep
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      rsel <= '0;
      per  <= '0;
      lvl  <= '0;
      inv  <= '0;
      cmp  <= '0;
    end else if (we) begin
      if (addr == AW'(A_CTRL)) begin
        en   <= wdata[0];
        rsel <= wdata[3:1];
      end
      if (addr == AW'(A_PER)) per <= wdata;
      if (addr == AW'(A_LVL)) begin
        lvl <= wdata[NCH-1:0];
        inv <= wdata[INV_LSB +: NCH];
      end
      for (int j = 0; j < NCH; j++) begin
        if (addr == AW'(A_CMP + j)) cmp[j] <= wdata;
      end
    end
  end

  assign clr  = we && (addr == AW'(A_FCLR));
  assign keep = wdata[NCH-1:0];

endmodule

// File: rtl/pdw_timer.sv
`timescale 1ns/1ps
module pdw_timer
  import pdw_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  tmode_e        mode,
  input  logic [TW-1:0] top_val,
  output logic [TW-1:0] cnt,
  output logic          hold,
  output logic          live
);

  logic at_top;

  assign at_top = (mode != MODE_FREE) && (cnt == top_val);
  assign live   = en && !hold;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (hold) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (at_top) begin
      hold <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pdw_chan.sv
`timescale 1ns/1ps
module pdw_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          live,
  input  logic          freeze,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] cmp,
  input  logic          lvl,
  input  logic          inv,
  input  logic          clr,
  input  logic          keep,
  output logic          wave,
  output logic          flag,
  output logic          hit
);

  logic st, st_nxt;

  assign hit = live && (cnt == cmp);

  always_comb begin
    if (!en || freeze) st_nxt = lvl;
    else if (hit)      st_nxt = ~st;
    else               st_nxt = st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= 1'b0;
      wave <= 1'b0;
      flag <= 1'b0;
    end else begin
      st   <= st_nxt;
      wave <= st_nxt ^ inv;
      if (hit)              flag <= 1'b1;
      else if (clr && !keep) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pdw_gen.sv
`timescale 1ns/1ps
module pdw_gen
  import pdw_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [TW-1:0]  wdata_i,
  output logic [NCH-1:0] wave_o,
  output logic [NCH-1:0] flag_o
);

  logic                   en_q;
  logic [2:0]             rsel_q;
  logic [TW-1:0]          per_q;
  logic [NCH-1:0]         lvl_q, inv_q;
  logic [NCH-1:0][TW-1:0] cmp_q;
  logic                   clr_w;
  logic [NCH-1:0]         keep_w;
  tmode_e                 mode;
  logic [TW-1:0]          top_val;
  logic [TW-1:0]          cnt_q;
  logic                   hold_q, live_w;
  logic [NCH-1:0]         hit_v;

  pdw_regs #(.NCH(NCH), .TW(TW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(we_i), .addr(addr_i), .wdata(wdata_i),
    .en(en_q), .rsel(rsel_q), .per(per_q), .lvl(lvl_q), .inv(inv_q),
    .cmp(cmp_q), .clr(clr_w), .keep(keep_w)
  );

  assign mode    = pick_mode(rsel_q);
  assign top_val = (mode == MODE_CMP0) ? cmp_q[0] : per_q;

  pdw_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .en(en_q), .mode(mode), .top_val(top_val),
    .cnt(cnt_q), .hold(hold_q), .live(live_w)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    pdw_chan #(.TW(TW)) u_ch (
      .clk(clk), .rst(rst), .en(en_q), .live(live_w),
      .freeze((j == 0) && (mode == MODE_CMP0)),
      .cnt(cnt_q), .cmp(cmp_q[j]), .lvl(lvl_q[j]), .inv(inv_q[j]),
      .clr(clr_w), .keep(keep_w[j]),
      .wave(wave_o[j]), .flag(flag_o[j]), .hit(hit_v[j])
    );
  end

endmodule

// File: rtl/pdw_gen_chk.sv
`timescale 1ns/1ps
module pdw_gen_chk
  import pdw_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input tmode_e         mode,
  input logic           hold,
  input logic [TW-1:0]  cnt,
  input logic [NCH-1:0] lvl,
  input logic [NCH-1:0] inv,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] wave,
  input logic [NCH-1:0] flag
);

  // R2
  dis_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> wave == $past(lvl ^ inv));

  // R2
  dis_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);

  // R3
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_FREE && !hold) |=> cnt == TW'($past(cnt) + 1'b1));

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0) && !hold);

  // R8
  hit_live_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |-> (en && !hold));

  // R4
  ch0_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CMP0) |=> wave[0] == $past(lvl[0] ^ inv[0]));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((flag & $past(hit)) == $past(hit)));

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((flag & ~$past(flag) & ~$past(hit)) == '0));

endmodule

bind pdw_gen pdw_gen_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .en(en_q), .mode(mode), .hold(hold_q),
  .cnt(cnt_q), .lvl(lvl_q), .inv(inv_q), .hit(hit_v),
  .wave(wave_o), .flag(flag_o)
);

// File: tb/pdw_gen_bench.sv
`timescale 1ns/1ps
module pdw_gen_bench;
  localparam int NCH = 8;
  localparam int TW  = 16;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [TW-1:0]  wdata = '0;
  logic [NCH-1:0] wave, flag;

  always #2 clk = ~clk;

  pdw_gen #(.NCH(NCH), .TW(TW), .AW(AW)) u_pdw_gen (
    .clk(clk), .rst(rst), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .wave_o(wave), .flag_o(flag)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of the requirements
  bit          men;
  logic [2:0]  msel;
  logic [15:0] mper;
  logic [7:0]  mlvl, minv, mst, mwave, mflag;
  logic [15:0] mcmp [NCH];
  logic [15:0] mcnt;
  bit          mhold;

  function automatic int mode_of(input logic [2:0] s);
    return (s == 3'b001) ? 1 : (s == 3'b010) ? 2 : 0;
  endfunction

  always @(posedge clk) begin : model
    int md;
    bit live, hit;
    logic [15:0] topv;
    logic [7:0] nst, nf;
    if (rst) begin
      men = 0; msel = 0; mper = 0; mlvl = 0; minv = 0; mst = 0; mwave = 0; mflag = 0;
      mcnt = 0; mhold = 0;
      for (int j = 0; j < NCH; j++) mcmp[j] = 0;
    end else begin
      md   = mode_of(msel);
      live = men && !mhold;
      for (int j = 0; j < NCH; j++) begin
        hit = live && (mcnt == mcmp[j]);
        if (!men || (j == 0 && md == 1)) nst[j] = mlvl[j];
        else if (hit)                    nst[j] = ~mst[j];
        else                             nst[j] = mst[j];
        if (hit) nf[j] = 1'b1;
        else if (we && addr == 4'd3 && !wdata[j]) nf[j] = 1'b0;
        else nf[j] = mflag[j];
      end
      topv = (md == 1) ? mcmp[0] : mper;
      if (!men || mhold) begin
        mcnt = 0; mhold = 0;
      end else if (md != 0 && mcnt == topv) mhold = 1;
      else mcnt = mcnt + 16'd1;
      mwave = nst ^ minv;
      mst   = nst;
      mflag = nf;
      if (we) begin
        if (addr == 4'd0) begin men = wdata[0]; msel = wdata[3:1]; end
        if (addr == 4'd1) mper = wdata;
        if (addr == 4'd2) begin mlvl = wdata[7:0]; minv = wdata[15:8]; end
        if (addr >= 4'd8) mcmp[addr - 4'd8] = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      string tw;
      if (!men) tw = "R2 idle output";
      else case (mode_of(msel))
        1:       tw = "R4 cmp0-restart output";
        2:       tw = "R5 period-restart output";
        default: tw = "R3 free-run output";
      endcase
      check(wave === mwave, tw, 32'(wave), 32'(mwave));
      check(flag === mflag, "R6/R7 flags", 32'(flag), 32'(mflag));
    end
  end

  // caller stands at a negedge; sampled at the next posedge
  task automatic wr(input int a, input logic [15:0] d);
    we = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic gap(input int c, input int lim, output int n);
    logic prev;
    prev = wave[c];
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (wave[c] == prev && n < lim);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int n;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1
    check(wave == 8'h00, "R1 outputs after reset", 32'(wave), 0);
    check(flag == 8'h00, "R1 flags after reset", 32'(flag), 0);

    // R2 / R10 idle levels with inversion
    wr(2, 16'hA53C);
    @(negedge clk);
    check(wave == 8'h99, "R2 idle level xor invert", 32'(wave), 32'h99);
    wr(2, 16'h0000);
    @(negedge clk);

    // R9 phase from enable, R3 free-run period
    for (int j = 0; j < NCH; j++) wr(8 + j, (j == 3) ? 16'd5 : 16'(100 + j));
    wr(0, 16'h0001);
    gap(3, 100, n);
    check(n == 6, "R9 first toggle at m+1", n, 6);
    gap(3, 70000, n);
    check(n == 65536, "R3 free-run toggle gap", n, 65536);
    wr(0, 16'h0000);
    @(negedge clk);
    check(wave == 8'h00, "R2 outputs return to idle", 32'(wave), 0);

    // R4 channel-0 restart, n = 10
    wr(8, 16'd10);
    wr(11, 16'd4);
    wr(0, 16'h0003);
    gap(3, 100, n);
    gap(3, 100, n);
    check(n == 12, "R4 toggle gap n+2", n, 12);
    gap(3, 100, n);
    check(n == 12, "R4 second toggle gap", n, 12);
    check(wave[0] == 1'b0, "R4 channel 0 held idle", 32'(wave[0]), 0);
    wr(0, 16'h0000);

    // R5 period-register restart, n = 20; R8 channel at n
    wr(1, 16'd20);
    wr(13, 16'd20);
    wr(0, 16'h0005);
    gap(3, 100, n);
    gap(3, 100, n);
    check(n == 22, "R5 toggle gap n+2", n, 22);
    gap(5, 100, n);
    gap(5, 100, n);
    check(n == 22, "R8 channel at restart value toggles once", n, 22);
    wr(0, 16'h0000);

    // R10 unlisted select decodes as free-run: channel 0 not frozen
    wr(0, 16'h000F);
    gap(0, 100, n);
    check(n == 11, "R10 select 111 runs free, ch0 toggles", n, 11);
    wr(0, 16'h0000);

    // R6 / R7 flag set, clear, and match priority
    wr(3, 16'h0000);
    for (int j = 0; j < NCH; j++) wr(8 + j, 16'(150 + j));
    wr(10, 16'd7);
    wr(12, 16'd2);
    wr(14, 16'd4);
    wr(1, 16'd200);
    wr(0, 16'h0005);
    repeat (7) @(negedge clk);
    check((flag & 8'h54) == 8'h50, "R6 flags set by match", 32'(flag & 8'h54), 32'h50);
    wr(3, 16'h00EB);
    check(flag[2] == 1'b1, "R7 match wins over clear", 32'(flag[2]), 1);
    check(flag[4] == 1'b0, "R7 zero bit clears", 32'(flag[4]), 0);
    check(flag[6] == 1'b1, "R7 one bit leaves flag", 32'(flag[6]), 1);

    // seeded random mix, compared every cycle against the model
    for (int it = 0; it < 30; it++) begin
      int sel, a;
      logic [15:0] d;
      sel = int'($urandom % 6);
      case (sel)
        0: begin a = 0; d = {12'h0, 3'($urandom), 1'(($urandom % 4) != 0)}; end
        1: begin a = 1; d = 16'(2 + $urandom % 60); end
        2: begin a = 2; d = 16'($urandom); end
        3: begin a = 3; d = 16'($urandom); end
        default: begin a = 8 + int'($urandom % 8); d = 16'($urandom % 64); end
      endcase
      wr(a, d);
      repeat (1 + $urandom % 200) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule